// File: doc/BRIEF.md
# Compare-Based Timer Channel Bank

This block holds a small bank of identical timer channels for one processor core. Every channel watches a shared, free-running 64-bit system count. The count may advance by more than one per step when the count source runs at a coarser update granularity. Each channel compares the count against its own programmed 64-bit deadline. The channel raises a level interrupt once the count has reached or gone past that deadline. Because the test is greater-or-equal, a count that steps over the exact deadline value still fires.

Software sets a deadline in one of two ways. It can write the absolute 64-bit value. It can also write a signed 32-bit relative delay; the hardware then adds that delay to the count of the write cycle to form the absolute deadline. Reading the delay register returns the time remaining until the deadline. Each channel has a control register that holds an enable, an interrupt mask and a read-only raw status bit, so software can poll instead of taking the interrupt.

The register port is a single write strobe with an address and a data word. Reads are combinational from the address. The address is {channel, offset}; the offset is two bits wide.

Top module: `tmr_cmp_bank`

## Requirements
- R1: After reset, every channel has enable=0, mask=0 and deadline=0. All interrupts are low, and reads of the control register and the deadline register return 0.
- R2: A write to offset 1 (deadline) loads all 64 data bits as the channel's deadline. A read of offset 1 returns the deadline.
- R3: The timer condition is true when the system count is greater than or equal to the deadline. The comparison is unsigned over the full 64 bits, so a count that has jumped past the deadline also satisfies it.
- R4: The interrupt of a channel equals enable AND condition AND NOT mask. In the control register, enable is bit 0 and mask is bit 1.
- R5: Control bit 2 is the raw status. It reads as the condition while enable is 1 and as 0 while enable is 0. Writes to bit 2 are ignored.
- R6: A write to offset 2 (delay) sets the deadline to the system count of the write cycle plus wdata[31:0] sign-extended to 64 bits.
- R7: A read of offset 2 returns the low 32 bits of (deadline minus current count) in rdata[31:0], with the upper bits 0.
- R8: Channels are independent. The address is {channel index, offset}, and a write affects only the addressed channel. Offset 3 reads as 0 and writes to it change nothing.
- R9: A newly written deadline or control value affects the interrupt from the cycle after the write edge. The condition is evaluated against the live count in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count_i | input | 64 | Shared system count |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | {channel[1:0], offset[1:0]} |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Combinational read data for addr_i |
| irq_o | output | 4 | Level interrupt, one per channel |

## Verification
The hold property assumes that the system count never decreases between two cycles in which no register is written. Under that assumption an asserted interrupt must stay asserted. The bench meets this by moving the count only between write phases, and every step it makes goes forward except where it sets up a fresh table vector; writes take place at those points. The other properties assume that the inputs are stable across the clock edge, so the bench drives every input on the falling edge.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
    localparam int OFF_W = 2;

    typedef enum logic [OFF_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_DLINE = 2'd1,
        REG_DELAY = 2'd2,
        REG_RSVD  = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MASK = 1;
    localparam int CTRL_STAT = 2;
    localparam int CTRL_W    = 3;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DLY_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [CNT_W-1:0]  wdata,
    output logic              irq_o,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  dline_rd,
    output logic [DLY_W-1:0]  delay_rd
);
    typedef struct packed {
        logic             en;
        logic             mask;
        logic [CNT_W-1:0] dline;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic [CNT_W-1:0] delay_ext;
    logic [CNT_W-1:0] remain;
    logic             cond;

    assign delay_ext = {{(CNT_W-DLY_W){wdata[DLY_W-1]}}, wdata[DLY_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                REG_CTRL: begin
                    st_d.en   = wdata[CTRL_EN];
                    st_d.mask = wdata[CTRL_MASK];
                end
                REG_DLINE: st_d.dline = wdata;
                REG_DELAY: st_d.dline = sys_count + delay_ext;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond     = (sys_count >= st_q.dline);
    assign irq_o    = st_q.en & cond & ~st_q.mask;
    assign remain   = st_q.dline - sys_count;
    assign delay_rd = remain[DLY_W-1:0];
    assign dline_rd = st_q.dline;
    assign ctrl_rd  = {st_q.en & cond, st_q.mask, st_q.en};

    p_dline_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_DLINE) |=> (dline_rd == $past(wdata)));

    p_delay_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_DELAY) |=>
        (dline_rd == $past(sys_count) + $past(delay_ext)));

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == REG_CTRL && !wdata[CTRL_EN]) |=> !irq_o);

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_o) && !$past(wr_en) && sys_count >= $past(sys_count)) |-> irq_o);
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_cmp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 64,
    parameter int DLY_W  = 32,
    parameter int CH_W   = 2
) (
    input  logic [CH_W-1:0]               ch_idx,
    input  reg_sel_e                      sel,
    input  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  dline_rd,
    input  logic [NUM_CH-1:0][DLY_W-1:0]  delay_rd,
    output logic [CNT_W-1:0]              rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == CH_W'(k)) begin
                case (sel)
                    REG_CTRL:  rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_rd[k]};
                    REG_DLINE: rdata = dline_rd[k];
                    REG_DELAY: rdata = {{(CNT_W-DLY_W){1'b0}}, delay_rd[k]};
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
    import tmr_cmp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 64,
    parameter int DLY_W  = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [NUM_CH-1:0] irq_o
);
    logic [CH_W-1:0]               ch_idx;
    reg_sel_e                      sel;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]  dline_rd;
    logic [NUM_CH-1:0][DLY_W-1:0]  delay_rd;

    assign ch_idx = addr_i[ADDR_W-1:OFF_W];
    assign sel    = reg_sel_e'(addr_i[OFF_W-1:0]);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic ch_wr;
        assign ch_wr = wr_en_i && (ch_idx == CH_W'(k));

        tmr_chan #(.CNT_W(CNT_W), .DLY_W(DLY_W)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sys_count (sys_count_i),
            .wr_en     (ch_wr),
            .wr_sel    (sel),
            .wdata     (wdata_i),
            .irq_o     (irq_o[k]),
            .ctrl_rd   (ctrl_rd[k]),
            .dline_rd  (dline_rd[k]),
            .delay_rd  (delay_rd[k])
        );

        p_stat_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_idx == CH_W'(k) && sel == REG_CTRL && !rdata_o[CTRL_MASK])
            |-> (rdata_o[CTRL_STAT] == irq_o[k]));

        p_other_ch_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && ch_idx != CH_W'(k)) |=> $stable(dline_rd[k]));
    end

    tmr_rd_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DLY_W(DLY_W), .CH_W(CH_W)) i_rd_mux (
        .ch_idx   (ch_idx),
        .sel      (sel),
        .ctrl_rd  (ctrl_rd),
        .dline_rd (dline_rd),
        .delay_rd (delay_rd),
        .rdata    (rdata_o)
    );
endmodule

// File: tb/test_tmr_cmp_bank.sv
module test_tmr_cmp_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_cmp_bank i_tmr_cmp_bank (
        .clk(clk), .rst_n(rst_n), .sys_count_i(sys_count), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [63:0] cnt;
        logic [63:0] dl;
        logic        en;
        logic        mask;
        logic        exp_irq;
        logic        exp_stat;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{64'd100, 64'd100, 1'b1, 1'b0, 1'b1, 1'b1},
        '{64'd99,  64'd100, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'd150, 64'd100, 1'b1, 1'b0, 1'b1, 1'b1},
        '{64'd150, 64'd100, 1'b1, 1'b1, 1'b0, 1'b1},
        '{64'd150, 64'd100, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_0000_0000, 64'h0000_0001_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1},
        '{64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] off, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = {ch, off}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] ch, input logic [1:0] off, output logic [63:0] d);
        addr = {ch, off};
        #1;
        d = rdata;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {60'd0, irq}, 64'd0);
        rd(2'd0, 2'd0, r); chk("R1 ctrl", r, 64'd0);
        rd(2'd0, 2'd1, r); chk("R1 dline", r, 64'd0);
        rd(2'd3, 2'd2, r); chk("R1 delay", r, 64'd0);

        // R3 R4 R5 vector walk on channel 0
        foreach (VECS[i]) begin
            @(negedge clk);
            sys_count = VECS[i].cnt;
            wr(2'd0, 2'd1, VECS[i].dl);
            wr(2'd0, 2'd0, {62'd0, VECS[i].mask, VECS[i].en});
            chk("R3 R4 irq", {63'd0, irq[0]}, {63'd0, VECS[i].exp_irq});
            rd(2'd0, 2'd0, r);
            chk("R5 stat", {63'd0, r[2]}, {63'd0, VECS[i].exp_stat});
        end
        wr(2'd0, 2'd0, 64'd0);

        // R2 deadline readback
        wr(2'd1, 2'd1, 64'h1234_5678_9ABC_DEF0);
        rd(2'd1, 2'd1, r); chk("R2 dline", r, 64'h1234_5678_9ABC_DEF0);

        // R6 delay write, positive and negative
        @(negedge clk); sys_count = 64'd1000;
        wr(2'd1, 2'd2, 64'd50);
        rd(2'd1, 2'd1, r); chk("R6 pos", r, 64'd1050);
        wr(2'd2, 2'd2, 64'h0000_0000_FFFF_FFF6);
        rd(2'd2, 2'd1, r); chk("R6 neg", r, 64'd990);

        // R7 delay readback
        @(negedge clk); sys_count = 64'd1020;
        rd(2'd1, 2'd2, r); chk("R7 remain", r, 64'd30);
        @(negedge clk); sys_count = 64'd1060;
        rd(2'd1, 2'd2, r); chk("R7 wrapped", r, 64'h0000_0000_FFFF_FFF6);

        // R9 new deadline takes effect the cycle after the write edge
        @(negedge clk); sys_count = 64'd1500;
        wr(2'd2, 2'd1, 64'd1600);
        wr(2'd2, 2'd0, 64'd1);
        chk("R9 before", {63'd0, irq[2]}, 64'd0);
        @(negedge clk);
        wr_en = 1'b1; addr = {2'd2, 2'd1}; wdata = 64'd1400;
        #1; chk("R9 same cycle", {63'd0, irq[2]}, 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 after", {63'd0, irq[2]}, 64'd1);

        // R8 independence and reserved offset
        wr(2'd3, 2'd1, 64'd5);
        wr(2'd3, 2'd0, 64'd1);
        chk("R8 irq map", {60'd0, irq}, 64'hC);
        rd(2'd2, 2'd1, r); chk("R8 other ch", r, 64'd1400);
        wr(2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, 2'd3, r); chk("R8 rsvd read", r, 64'd0);
        rd(2'd0, 2'd0, r); chk("R8 rsvd no effect", r, 64'd0);
        chk("R8 rsvd irq", {60'd0, irq}, 64'hC);

        // R5 status write ignored, disabled status reads 0
        wr(2'd3, 2'd0, 64'd4);
        rd(2'd3, 2'd0, r); chk("R5 stat wr ignored", r, 64'd0);
        chk("R4 disabled irq", {63'd0, irq[3]}, 64'd0);

        done = 1'b1;
        report();
    end
endmodule